// File: doc/BRIEF.md
# Output expander chain driver

This block feeds a daisy chain of serial-in, parallel-out power shift registers, each eight bits wide, from a small level file held inside the block. A start request serialises the whole chain image on a data line with its own shift clock. A latch line stays low for the whole frame, much like a select. It rises after the last bit, so every output of every device updates in the same instant. The chain image is always padded to eight bits per device. Positions with no output behind them carry zero.

Each output holds a small brightness level. In single-frame mode an output is on when its level is non-zero. In multi-frame mode one start sends a burst of bit-plane frames, and a given output is on in frame k when its level exceeds k. This gives as many brightness steps as there are frames. The active-low output enable keeps every load off from reset until the first image has been latched. It can then be gated by a free-running PWM for bulk dimming. Levels are written through a valid/ready port that never applies back-pressure (ready is tied high). A write is seen by every frame started after it.

Top module: `oxd_chain_driver`

## Requirements
- R1: After reset `latch` is high, `sclk` is low, `busy` and `done` are low, and `oe_n` is high. `oe_n` stays high until the first rising edge of `latch` after reset, even with dimming off.
- R2: Between the falling and the rising edge of `latch`, exactly 8*N_DEV rising edges of `sclk` occur. `latch` is never low while the block is idle.
- R3: Chain position j is bit j%8 of device j/8, where device 0 is nearest the driver. Bits are sent from position 8*N_DEV-1 down to position 0, so the first bit sent lands in the farthest device.
- R4: Positions from N_OUT up to 8*N_DEV-1 are always sent as 0. A write whose `wr_idx` is N_OUT or larger changes no level.
- R5: Each low and each high half of `sclk` inside a frame lasts max(`div`,1)+1 clocks. `sdo` never changes while `sclk` is high. `sclk` is low whenever `busy` is low.
- R6: With `multi` low at start, one frame is sent. In it position j (j < N_OUT) is 1 exactly when the level of output j is non-zero.
- R7: With `multi` high at start, PLANES frames are sent, with k = 0 first. In frame k, position j (j < N_OUT) is 1 exactly when the level of output j is greater than k.
- R8: A `start` pulse seen while `busy` is high is ignored. A `start` seen while idle makes `busy` high in the next cycle, even in the cycle `done` is high.
- R9: After every rise of `latch` the line stays high for 2*(max(`div`,1)+1) clocks before the next frame drops it or the burst ends. `done` is then high for exactly one clock, with `latch` high and `busy` low.
- R10: Once armed, `oe_n` is low at all times while `dim_en` is low. While `dim_en` is high, `oe_n` is low in exactly `dim_duty` of every 2^PWM_W consecutive clocks.
- R11: `wr_ready` is always 1. A write with `wr_valid` high sets the level of output `wr_idx` to `wr_level` for every frame started afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Level write request |
| wr_ready | output | 1 | Write accept, always 1 |
| wr_idx | input | $clog2(8*N_DEV) | Output index to write |
| wr_level | input | $clog2(PLANES) | Brightness level |
| start | input | 1 | Begin a refresh (one frame or a burst) |
| multi | input | 1 | 1 selects the multi-frame burst |
| div | input | DIV_W | Shift-clock half period minus one, minimum 1 |
| dim_en | input | 1 | Enable PWM gating of the output enable |
| dim_duty | input | PWM_W | On-clocks per PWM period |
| sclk | output | 1 | Chain shift clock |
| sdo | output | 1 | Chain serial data |
| latch | output | 1 | Chain register clock, low during a frame |
| oe_n | output | 1 | Active-low chain output enable |
| busy | output | 1 | Refresh in progress |
| done | output | 1 | One-clock end-of-refresh pulse |

## Verification
The close call is a `start` that arrives in the same clock as the `done` pulse of the refresh before it. The bench watches for `done` and raises `start` at once. The new request must be taken, and a second complete frame must follow with its own latch edge and its own `done`. The other pairing is a second `start` raised during a frame. That one must leave exactly one latch edge and one `done` for the run.

// File: rtl/oxd_pkg.sv
package oxd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } ser_state_t;
endpackage

// File: rtl/oxd_level_file.sv
module oxd_level_file #(
  parameter int TOT    = 16,
  parameter int N_OUT  = 12,
  parameter int PLANES = 4,
  localparam int IDX_W = $clog2(TOT),
  localparam int LVL_W = $clog2(PLANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LVL_W-1:0] wr_level,
  input  logic [LVL_W-1:0] plane,
  input  logic             multi,
  output logic [TOT-1:0]   frame_bits
);
  for (genvar g = 0; g < TOT; g++) begin : g_pos
    if (g < N_OUT) begin : g_live
      logic [LVL_W-1:0] lvl;
      always_ff @(posedge clk) begin
        if (!rst_n)
          lvl <= '0;
        else if (wr_valid && wr_idx == IDX_W'(g))
          lvl <= wr_level;
      end
      assign frame_bits[g] = multi ? (lvl > plane) : (|lvl);
    end else begin : g_pad
      assign frame_bits[g] = 1'b0;
    end
  end
endmodule

// File: rtl/oxd_serializer.sv
module oxd_serializer
  import oxd_pkg::*;
#(
  parameter int TOT    = 16,
  parameter int PLANES = 4,
  parameter int DIV_W  = 4,
  localparam int POS_W = $clog2(TOT),
  localparam int PLW   = $clog2(PLANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  input  logic [DIV_W-1:0] div,
  input  logic [TOT-1:0]   frame_bits,
  output logic [PLW-1:0]   plane,
  output logic             mode,
  output logic             sclk,
  output logic             sdo,
  output logic             latch,
  output logic             busy,
  output logic             done
);
  ser_state_t       st;
  logic [POS_W-1:0] pos;
  logic [DIV_W-1:0] hl_q, hc;
  logic [DIV_W:0]   hold_c;
  logic             last_plane;

  assign busy       = (st != ST_IDLE);
  assign last_plane = !mode || (plane == PLW'(PLANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pos    <= '0;
      plane  <= '0;
      mode   <= 1'b0;
      hl_q   <= DIV_W'(1);
      hc     <= '0;
      hold_c <= '0;
      sclk   <= 1'b0;
      sdo    <= 1'b0;
      latch  <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st    <= ST_SHIFT;
            latch <= 1'b0;
            pos   <= POS_W'(TOT - 1);
            plane <= '0;
            mode  <= multi;
            hl_q  <= (div == '0) ? DIV_W'(1) : div;
            hc    <= '0;
            sclk  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (!sclk && hc == '0)
            sdo <= frame_bits[pos];
          if (hc == hl_q) begin
            hc   <= '0;
            sclk <= !sclk;
            if (sclk) begin
              if (pos == '0) begin
                st     <= ST_HOLD;
                latch  <= 1'b1;
                hold_c <= '0;
              end else begin
                pos <= pos - POS_W'(1);
              end
            end
          end else begin
            hc <= hc + DIV_W'(1);
          end
        end
        ST_HOLD: begin
          if (hold_c == {hl_q, 1'b1}) begin
            if (last_plane) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st    <= ST_SHIFT;
              plane <= plane + PLW'(1);
              pos   <= POS_W'(TOT - 1);
              latch <= 1'b0;
              hc    <= '0;
            end
          end else begin
            hold_c <= hold_c + (DIV_W+1)'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oxd_blanker.sv
module oxd_blanker #(
  parameter int PWM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch,
  input  logic             dim_en,
  input  logic [PWM_W-1:0] duty,
  output logic             oe_n
);
  logic             armed, latch_prev;
  logic [PWM_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      latch_prev <= 1'b1;
      pcnt       <= '0;
    end else begin
      latch_prev <= latch;
      pcnt       <= pcnt + PWM_W'(1);
      if (latch && !latch_prev)
        armed <= 1'b1;
    end
  end

  assign oe_n = !(armed && (!dim_en || (pcnt < duty)));
endmodule

// File: rtl/oxd_chain_driver.sv
module oxd_chain_driver #(
  parameter int N_DEV  = 2,
  parameter int N_OUT  = 12,
  parameter int PLANES = 4,
  parameter int DIV_W  = 4,
  parameter int PWM_W  = 4,
  localparam int TOT   = 8 * N_DEV,
  localparam int IDX_W = $clog2(TOT),
  localparam int LVL_W = $clog2(PLANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LVL_W-1:0] wr_level,
  input  logic             start,
  input  logic             multi,
  input  logic [DIV_W-1:0] div,
  input  logic             dim_en,
  input  logic [PWM_W-1:0] dim_duty,
  output logic             sclk,
  output logic             sdo,
  output logic             latch,
  output logic             oe_n,
  output logic             busy,
  output logic             done
);
  logic [TOT-1:0]   frame_bits;
  logic [LVL_W-1:0] plane;
  logic             mode;

  assign wr_ready = 1'b1;

  oxd_level_file #(.TOT(TOT), .N_OUT(N_OUT), .PLANES(PLANES)) u_levels (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_level(wr_level), .plane(plane), .multi(mode), .frame_bits(frame_bits)
  );

  oxd_serializer #(.TOT(TOT), .PLANES(PLANES), .DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .div(div),
    .frame_bits(frame_bits), .plane(plane), .mode(mode), .sclk(sclk),
    .sdo(sdo), .latch(latch), .busy(busy), .done(done)
  );

  oxd_blanker #(.PWM_W(PWM_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .latch(latch), .dim_en(dim_en),
    .duty(dim_duty), .oe_n(oe_n)
  );
endmodule

// File: rtl/oxd_chain_driver_chk.sv
module oxd_chain_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdo,
  input logic latch,
  input logic oe_n,
  input logic dim_en
);
  logic lat_p, seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_p <= 1'b1;
      seen  <= 1'b0;
    end else begin
      lat_p <= latch;
      if (latch && !lat_p) seen <= 1'b1;
    end
  end

  p_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> oe_n);
  p_latch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |-> busy);
  p_sdo_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
  p_idle_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  p_start_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (latch && !busy));
  p_lit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !dim_en) |-> !oe_n);
endmodule

bind oxd_chain_driver oxd_chain_driver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sclk(sclk), .sdo(sdo), .latch(latch), .oe_n(oe_n), .dim_en(dim_en)
);

// File: tb/oxd_chain_driver_test.sv
module oxd_chain_driver_test;
  localparam int NDEV = 2, NOUT = 12, PLANES = 4, TOT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, start = 1'b0, multi = 1'b0, dim_en = 1'b0;
  logic [3:0] wr_idx = '0, div = 4'd1, dim_duty = '0;
  logic [1:0] wr_level = '0;
  logic wr_ready, sclk, sdo, latch, oe_n, busy, done;

  always #5 clk = !clk;

  oxd_chain_driver uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_level(wr_level), .start(start), .multi(multi),
    .div(div), .dim_en(dim_en), .dim_duty(dim_duty), .sclk(sclk), .sdo(sdo),
    .latch(latch), .oe_n(oe_n), .busy(busy), .done(done)
  );

  // {multi, div, 12 levels of 2 bits, output j at [2j+1:2j]}
  localparam logic [28:0] VEC [6] = '{
    {1'b0, 4'd1, 24'hE41B39},
    {1'b1, 4'd2, 24'h1BE493},
    {1'b0, 4'd0, 24'hFFF000},
    {1'b1, 4'd1, 24'h55AAC3},
    {1'b1, 4'd4, 24'hE4E4E4},
    {1'b0, 4'd3, 24'h000001}
  };

  int n_chk = 0, n_bad = 0;
  logic [1:0] lvl_m [NOUT];

  // chain model and port monitor
  logic [TOT-1:0] chain = '0;
  logic [TOT-1:0] img [PLANES];
  logic ps_sclk = 1'b0, ps_latch = 1'b1, sdo_rise = 1'b0;
  int rises = 0, hi_run = 0, lo_run = 0, hold_run = 0, exp_half = 2;
  int bad_half = 0, bad_sdo = 0, bad_frame = 0, bad_hold = 0;
  int latch_cnt = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ps_sclk = 1'b0; ps_latch = 1'b1;
    end else begin
      if (!latch && ps_latch) begin
        if (latch_cnt > 0 && hold_run != 2 * exp_half) bad_hold++;
        rises = 0; lo_run = 0;
      end
      if (latch && !ps_latch) begin
        if (latch_cnt < PLANES) img[latch_cnt] = chain;
        latch_cnt++;
        if (rises != TOT) bad_frame++;
        hold_run = 0;
      end
      if (latch) hold_run++;
      if (sclk && !ps_sclk) begin
        chain = {chain[TOT-2:0], sdo};
        sdo_rise = sdo; rises++;
        if (lo_run != exp_half) bad_half++;
        lo_run = 0; hi_run = 1;
      end else if (sclk) begin
        hi_run++;
        if (sdo !== sdo_rise) bad_sdo++;
      end
      if (!sclk && ps_sclk && !latch && hi_run != exp_half) bad_half++;
      if (!sclk && ps_sclk && latch && rises == TOT && hi_run != exp_half) bad_half++;
      if (!sclk && !latch) lo_run++;
      if (done) done_cnt++;
      ps_sclk = sclk; ps_latch = latch;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [1:0] lv);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 4'(idx); wr_level = lv;
    @(negedge clk);
    wr_valid = 1'b0;
    if (idx < NOUT) lvl_m[idx] = lv;
  endtask

  function automatic logic [TOT-1:0] exp_img(input int pl, input bit mm);
    logic [TOT-1:0] r = '0;
    for (int j = 0; j < NOUT; j++)
      r[j] = mm ? (int'(lvl_m[j]) > pl) : (lvl_m[j] != 2'd0);
    return r;
  endfunction

  task automatic clear_mon();
    latch_cnt = 0; done_cnt = 0; bad_half = 0; bad_sdo = 0;
    bad_frame = 0; bad_hold = 0;
    exp_half = ((div == 4'd0) ? 1 : int'(div)) + 1;
  endtask

  task automatic wait_done(input int want);
    for (int t = 0; t < 20000 && done_cnt < want; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_one();
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(1);
  endtask

  task automatic check_run(input string tag);
    int nf;
    nf = multi ? PLANES : 1;
    chk(latch_cnt == nf, {tag, " R2 frame count"}, latch_cnt, nf);
    chk(bad_frame == 0, "R2 shift edges per frame", bad_frame, 0);
    chk(bad_half == 0 && bad_sdo == 0, "R5 half period and sdo hold",
        bad_half * 256 + bad_sdo, 0);
    chk(bad_hold == 0, "R9 latch hold between frames", bad_hold, 0);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    for (int p = 0; p < nf; p++)
      chk(img[p] == exp_img(p, multi), multi ? "R3 R7 plane image" : "R3 R6 image",
          int'(img[p]), int'(exp_img(p, multi)));
  endtask

  task automatic pwm_count(input logic [3:0] d, input int exp);
    int lows = 0;
    @(negedge clk); dim_duty = d;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (!oe_n) lows++;
    end
    chk(lows == exp, "R10 pwm low clocks in 64", lows, exp);
  endtask

  initial begin
    for (int j = 0; j < NOUT; j++) lvl_m[j] = 2'd0;
    repeat (3) @(negedge clk);
    chk(oe_n && latch && !sclk && !busy && !done, "R1 reset state",
        {oe_n, latch, sclk, busy, done}, 5'b11000);
    chk(wr_ready == 1'b1, "R11 wr_ready tied high", wr_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk
    for (int v = 0; v < 6; v++) begin
      for (int j = 0; j < NOUT; j++) wr(j, VEC[v][2*j +: 2]);
      multi = VEC[v][28]; div = VEC[v][27:24];
      if (v == 0) chk(oe_n == 1'b1, "R1 blank before first latch", oe_n, 1);
      run_one();
      check_run("R11");
      chk(oe_n == 1'b0, "R10 enabled with dimming off", oe_n, 0);
    end

    // padding and out-of-range writes
    multi = 1'b0; div = 4'd1;
    for (int j = 0; j < NOUT; j++) wr(j, 2'(j));
    for (int j = NOUT; j < TOT; j++) wr(j, 2'd3);
    run_one();
    chk(img[0][TOT-1:NOUT] == '0, "R4 padding positions zero",
        int'(img[0][TOT-1:NOUT]), 0);
    chk(img[0] == exp_img(0, 1'b0), "R4 no aliasing of high index",
        int'(img[0]), int'(exp_img(0, 1'b0)));

    // start while busy
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R8 busy mid frame", busy, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(1);
    repeat (200) @(negedge clk);
    chk(latch_cnt == 1 && done_cnt == 1, "R8 start ignored while busy",
        latch_cnt * 16 + done_cnt, 17);

    // start in the same cycle as done
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R8 start taken during done", busy, 1);
    wait_done(2);
    chk(latch_cnt == 2 && done_cnt == 2 && bad_frame == 0,
        "R9 back-to-back refresh", latch_cnt * 16 + done_cnt, 34);

    // PWM dimming
    dim_en = 1'b1;
    pwm_count(4'd5, 20);
    pwm_count(4'd0, 0);
    pwm_count(4'd15, 60);
    dim_en = 1'b0;
    pwm_count(4'd3, 64);

    // reset again: blanked until next latch, levels cleared
    @(negedge clk); rst_n = 1'b0;
    for (int j = 0; j < NOUT; j++) lvl_m[j] = 2'd0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(oe_n == 1'b1, "R1 blank after second reset", oe_n, 1);
    run_one();
    chk(img[0] == '0, "R1 levels cleared by reset", int'(img[0]), 0);
    chk(oe_n == 1'b0, "R1 enabled after first latch", oe_n, 0);

    summary();
    $finish;
  end
endmodule